// File: doc/BRIEF.md
# Multi-channel PWM generator bank

This block turns a small set of word-wide registers into a number of independent pulse-width-modulated output pins. Each channel holds a period and a high time, both in cycles of the block clock. When the channel is switched on, it drives its pin active for the first high-time cycles of each period and idle for the rest. A channel runs in one of two ways. In continuous mode it repeats its period for as long as it stays enabled. In burst mode it emits a programmed number of periods and then parks its pin at the idle level.

Software reaches the registers over a plain single-cycle bus: a byte address, a write strobe, write data and combinational read data. Every channel owns a 32-byte window. The channel count (2, 4 or 8) and the build-time update policy are parameters. By default, new timing values are adopted at the next period boundary. The alternative build keeps a running channel on its old timing until software writes the enable bit as 1 again.

Each channel is a three-state machine. OFF is the disabled state. RUN emits periods. DONE is the idle state that follows a finished burst. The transitions are:
- START: OFF to RUN, or straight to DONE for a zero-length burst, taken on a control write with enable 1.
- STOP: RUN or DONE to OFF, taken on a control write with enable 0.
- FINISH: RUN to DONE, taken on the last period of a burst.
- REARM: DONE to RUN, taken on a control write with enable 1.

A control write with enable 1 in RUN keeps the state. In the hold-until-rearm build it marks pending timing for loading.

Top module: `pwm_bank`

## Requirements
- R1: After reset every pin is low, every busy flag is low and every register reads zero.
- R2: Channel n's window starts at byte n*0x20. Word 0x0 is the period, 0x4 the high time, 0x8 the burst count and 0xC the control word (bit 0 enable, bit 1 invert, bit 2 continuous). Reads return the last value written, with control bits above bit 2 reading 0. Offsets 0x10 to 0x1C read zero. Writing one register leaves every other register of every channel unchanged.
- R3: With continuous mode and enable set, period P > 0 and 0 < D < P, the pin is active for exactly D of every P cycles, with one rising edge per period.
- R4: With the invert bit set, the pin carries the complement of the non-inverted waveform.
- R5: A disabled channel's pin sits at the idle level: low, or high when the invert bit is set.
- R6: A high time of 0 gives a constant idle pin. A high time equal to or above the period gives a constant active pin. A period of 0 gives a constant idle pin.
- R7: With continuous mode clear and a burst count N > 0, enabling emits exactly N periods. The pin then stays idle. Busy is high while the burst runs and clears when it ends.
- R8: A burst count of 0 emits no pulse, and busy stays low.
- R9: After a burst has finished, a control write with enable 1 starts a fresh burst of the programmed length.
- R10: In the default build, a new period or high time written to a running channel takes effect at a period boundary. No period is cut short or doubled, so there is still one rising edge per period.
- R11: In the hold-until-rearm build, new timing written to a running channel does not change its output until the control word is written with enable 1. After that write, the new timing applies from the next period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the unit of period and high time |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address; channel in the upper bits, word offset in bits 4..2 |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the current address (combinational) |
| pwm_out | output | N_CH | One waveform pin per channel |
| busy | output | N_CH | High while a channel is in its RUN state |

## Verification
The following are checked on every clock:
- A disabled channel sits at its idle level whatever its invert setting.
- Busy is never high without the enable bit.
- Busy only falls because of a disable or because a burst ended in non-continuous mode.
- Reset silences every pin.

Duty ratios, pulse counts, the boundary-only adoption of new timing and the hold-until-rearm policy span whole periods. Only the bench scenarios show these: they count active cycles and rising edges over windows that are exact multiples of the period, so the result does not depend on phase.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    // word index inside a channel window (byte address bits 4..2)
    localparam logic [2:0] WRD_PERIOD = 3'd0;
    localparam logic [2:0] WRD_HIGH   = 3'd1;
    localparam logic [2:0] WRD_BURST  = 3'd2;
    localparam logic [2:0] WRD_CTRL   = 3'd3;

    // low address bits spanned by one channel window
    localparam int WIN_BITS = 5;

    // control word; en is bit 0, inv bit 1, keep bit 2
    typedef struct packed {
        logic keep;
        logic inv;
        logic en;
    } ctrl_t;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_RUN  = 2'd1,
        CH_DONE = 2'd2
    } ch_state_e;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int N_CH   = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 7
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [ADDR_W-1:0]              addr,
    input  logic                           we,
    input  logic [DATA_W-1:0]              wdata,
    output logic [DATA_W-1:0]              rdata,
    output logic [N_CH-1:0][DATA_W-1:0]    per_o,
    output logic [N_CH-1:0][DATA_W-1:0]    high_o,
    output logic [N_CH-1:0][DATA_W-1:0]    burst_o,
    output ctrl_t [N_CH-1:0]               ctrl_o,
    output logic [N_CH-1:0]                ctrl_wr_o
);

    localparam int CH_W = ADDR_W - WIN_BITS;

    logic            aligned;
    logic [CH_W-1:0] ch_sel;
    logic [2:0]      word;

    assign aligned = (addr[1:0] == 2'b00);
    assign ch_sel  = addr[ADDR_W-1:WIN_BITS];
    assign word    = addr[WIN_BITS-1:2];

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic hit;
        assign hit          = we && aligned && (ch_sel == CH_W'(g));
        assign ctrl_wr_o[g] = hit && (word == WRD_CTRL);

        always_ff @(posedge clk) begin
            if (rst) begin
                per_o[g]   <= '0;
                high_o[g]  <= '0;
                burst_o[g] <= '0;
                ctrl_o[g]  <= '0;
            end else if (hit) begin
                unique case (word)
                    WRD_PERIOD: per_o[g]   <= wdata;
                    WRD_HIGH:   high_o[g]  <= wdata;
                    WRD_BURST:  burst_o[g] <= wdata;
                    WRD_CTRL:   ctrl_o[g]  <= ctrl_t'(wdata[2:0]);
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (aligned) begin
            unique case (word)
                WRD_PERIOD: rdata = per_o[ch_sel];
                WRD_HIGH:   rdata = high_o[ch_sel];
                WRD_BURST:  rdata = burst_o[ch_sel];
                WRD_CTRL:   rdata = {{(DATA_W-3){1'b0}}, ctrl_o[ch_sel]};
                default:    rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_pkg::*;
#(
    parameter int DATA_W         = 32,
    parameter bit HOLD_UNTIL_ARM = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] per_i,
    input  logic [DATA_W-1:0] high_i,
    input  logic [DATA_W-1:0] burst_i,
    input  ctrl_t             ctrl_i,
    input  logic              ctrl_wr_i,
    input  ctrl_t             wr_ctrl_i,
    output logic              pwm_o,
    output logic              busy_o
);

    ch_state_e         st_q, st_d, start_tgt;
    logic [DATA_W-1:0] cnt_q, per_a, high_a, left_q;
    logic              pend_q, out_q;
    logic              arm, disarm, wrap, last_pulse, take_new, level, entering;

    assign arm        = ctrl_wr_i && wr_ctrl_i.en;
    assign disarm     = ctrl_wr_i && !wr_ctrl_i.en;
    assign wrap       = (per_a == '0) || (cnt_q >= per_a - 1'b1);
    assign last_pulse = wrap && (per_a != '0) && !ctrl_i.keep && (left_q <= 1);
    assign take_new   = !HOLD_UNTIL_ARM || pend_q;
    assign start_tgt  = (!wr_ctrl_i.keep && burst_i == '0) ? CH_DONE : CH_RUN;
    assign entering   = (st_q != CH_RUN) && (st_d == CH_RUN);

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= CH_OFF;
        else     st_q <= st_d;
    end

    // transitions: START, STOP, FINISH, REARM
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_OFF: begin
                if (arm) st_d = start_tgt;                  // START
            end
            CH_RUN: begin
                if (disarm)          st_d = CH_OFF;         // STOP
                else if (last_pulse) st_d = CH_DONE;        // FINISH
            end
            CH_DONE: begin
                if (disarm)   st_d = CH_OFF;                // STOP
                else if (arm) st_d = start_tgt;             // REARM
            end
            default: st_d = CH_OFF;
        endcase
    end

    // period counter and active timing
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            per_a  <= '0;
            high_a <= '0;
            left_q <= '0;
            pend_q <= 1'b0;
        end else if (entering) begin
            cnt_q  <= '0;
            per_a  <= per_i;
            high_a <= high_i;
            left_q <= burst_i;
            pend_q <= 1'b0;
        end else if (st_q == CH_RUN) begin
            if (HOLD_UNTIL_ARM && arm) pend_q <= 1'b1;
            if (wrap) begin
                cnt_q <= '0;
                if (take_new) begin
                    per_a  <= per_i;
                    high_a <= high_i;
                    pend_q <= 1'b0;
                end
                if (!ctrl_i.keep && per_a != '0 && left_q != '0)
                    left_q <= left_q - 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign level = (st_q == CH_RUN) && (per_a != '0) && (cnt_q < high_a);

    // registered pin
    always_ff @(posedge clk) begin
        if (rst) out_q <= 1'b0;
        else     out_q <= level ^ ctrl_i.inv;
    end

    assign pwm_o  = out_q;
    assign busy_o = (st_q == CH_RUN);

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_pkg::*;
#(
    parameter int N_CH           = 4,
    parameter int DATA_W         = 32,
    parameter bit HOLD_UNTIL_ARM = 1'b0,
    localparam int CH_W          = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int ADDR_W        = CH_W + WIN_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_CH-1:0]   pwm_out,
    output logic [N_CH-1:0]   busy
);

    logic [N_CH-1:0][DATA_W-1:0] per_r, high_r, burst_r;
    ctrl_t [N_CH-1:0]            ctrl_r;
    logic [N_CH-1:0]             ctrl_wr;
    ctrl_t                       wr_ctrl;
    logic [N_CH-1:0]             en_v, inv_v, keep_v;

    assign wr_ctrl = ctrl_t'(bus_wdata[2:0]);

    pwm_regs #(
        .N_CH   (N_CH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .addr      (bus_addr),
        .we        (bus_we),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .per_o     (per_r),
        .high_o    (high_r),
        .burst_o   (burst_r),
        .ctrl_o    (ctrl_r),
        .ctrl_wr_o (ctrl_wr)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_chan
        assign en_v[g]   = ctrl_r[g].en;
        assign inv_v[g]  = ctrl_r[g].inv;
        assign keep_v[g] = ctrl_r[g].keep;

        pwm_chan #(
            .DATA_W         (DATA_W),
            .HOLD_UNTIL_ARM (HOLD_UNTIL_ARM)
        ) u_chan (
            .clk       (clk),
            .rst       (rst),
            .per_i     (per_r[g]),
            .high_i    (high_r[g]),
            .burst_i   (burst_r[g]),
            .ctrl_i    (ctrl_r[g]),
            .ctrl_wr_i (ctrl_wr[g]),
            .wr_ctrl_i (wr_ctrl),
            .pwm_o     (pwm_out[g]),
            .busy_o    (busy[g])
        );
    end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
    parameter int N_CH = 4
) (
    input logic            clk,
    input logic            rst,
    input logic [N_CH-1:0] pwm_out,
    input logic [N_CH-1:0] busy,
    input logic [N_CH-1:0] en_v,
    input logic [N_CH-1:0] inv_v,
    input logic [N_CH-1:0] keep_v
);

    for (genvar g = 0; g < N_CH; g++) begin : g_prop
        // R1: the cycle after a reset cycle is quiet
        assert_reset_quiet_R1: assert property (@(posedge clk)
            rst |=> (pwm_out[g] == 1'b0 && busy[g] == 1'b0));

        // R5: disabled for two cycles with steady inversion gives the idle level
        assert_idle_level_R5: assert property (@(posedge clk) disable iff (rst)
            (!en_v[g] && !$past(en_v[g]) && inv_v[g] == $past(inv_v[g]))
            |-> pwm_out[g] == inv_v[g]);

        // R7: running requires the enable bit
        assert_busy_needs_en_R7: assert property (@(posedge clk) disable iff (rst)
            busy[g] |-> en_v[g]);

        // R7: busy ends only on disable or at the end of a counted burst
        assert_busy_end_R7: assert property (@(posedge clk) disable iff (rst)
            $fell(busy[g]) |-> (!en_v[g] || !$past(keep_v[g])));
    end

endmodule

bind pwm_bank pwm_bank_chk #(.N_CH(N_CH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .pwm_out (pwm_out),
    .busy    (busy),
    .en_v    (en_v),
    .inv_v   (inv_v),
    .keep_v  (keep_v)
);

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    // main instance: 4 channels, boundary update
    logic [6:0]  a_addr = '0;
    logic        a_we = 1'b0;
    logic [31:0] a_wdata = '0;
    logic [31:0] a_rdata;
    logic [3:0]  a_out, a_busy;

    // second instance: 2 channels, hold until re-arm
    logic [5:0]  b_addr = '0;
    logic        b_we = 1'b0;
    logic [31:0] b_wdata = '0;
    logic [31:0] b_rdata;
    logic [1:0]  b_out, b_busy;

    pwm_bank #(.N_CH(4), .DATA_W(32), .HOLD_UNTIL_ARM(1'b0)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(a_addr), .bus_we(a_we),
        .bus_wdata(a_wdata), .bus_rdata(a_rdata), .pwm_out(a_out), .busy(a_busy)
    );

    pwm_bank #(.N_CH(2), .DATA_W(32), .HOLD_UNTIL_ARM(1'b1)) u_dut_arm (
        .clk(clk), .rst(rst), .bus_addr(b_addr), .bus_we(b_we),
        .bus_wdata(b_wdata), .bus_rdata(b_rdata), .pwm_out(b_out), .busy(b_busy)
    );

    // scoreboard
    typedef struct {
        string       req;
        string       what;
        longint      val;
    } exp_t;

    exp_t   exp_q[$];
    longint act_v;
    event   ev_act;
    int     n_cmp = 0;
    int     n_bad = 0;
    bit     done = 1'b0;

    always begin
        @(ev_act);
        if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            n_cmp++;
            if (it.val != act_v) begin
                n_bad++;
                $display("FAIL %s %s: actual=%0d expected=%0d", it.req, it.what, act_v, it.val);
            end
        end
    end

    task automatic chk(input string req, input string what, input longint expv, input longint actv);
        exp_t it;
        it.req = req; it.what = what; it.val = expv;
        exp_q.push_back(it);
        act_v = actv;
        -> ev_act;
        #1;
    endtask

    function automatic logic [7:0] ad(input int ch, input int ofs);
        return 8'(ch * 32 + ofs);
    endfunction

    task automatic wr(input bit which, input logic [7:0] addr, input logic [31:0] data);
        @(negedge clk);
        if (which) begin b_addr = addr[5:0]; b_wdata = data; b_we = 1'b1; end
        else       begin a_addr = addr[6:0]; a_wdata = data; a_we = 1'b1; end
        @(negedge clk);
        a_we = 1'b0;
        b_we = 1'b0;
    endtask

    task automatic rd(input bit which, input logic [7:0] addr, output logic [31:0] data);
        @(negedge clk);
        if (which) b_addr = addr[5:0];
        else       a_addr = addr[6:0];
        #1;
        data = which ? b_rdata : a_rdata;
    endtask

    function automatic logic pin(input bit which, input int ch);
        return which ? b_out[ch] : a_out[ch];
    endfunction

    task automatic measure(input bit which, input int ch, input int n,
                           output int hi, output int edges);
        logic prev, cur;
        hi = 0; edges = 0;
        prev = pin(which, ch);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cur = pin(which, ch);
            if (cur) hi++;
            if (cur && !prev) edges++;
            prev = cur;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int hi, ed;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1", "pins after reset", 0, a_out);
        chk("R1", "busy after reset", 0, a_busy);
        rd(0, ad(3, 'h0), d); chk("R1", "ch3 period reset", 0, d);
        rd(1, ad(1, 'hC), d); chk("R1", "arm-build ch1 control reset", 0, d);

        // R2 register window and independence
        wr(0, ad(2, 'h0), 32'h1234_5678);
        wr(0, ad(2, 'h4), 32'h0000_00A5);
        wr(0, ad(2, 'h8), 32'd9);
        wr(0, ad(2, 'hC), 32'hFFFF_FFF6);
        rd(0, ad(2, 'h0), d); chk("R2", "ch2 period", 32'h1234_5678, d);
        rd(0, ad(2, 'h4), d); chk("R2", "ch2 high", 32'hA5, d);
        rd(0, ad(2, 'h8), d); chk("R2", "ch2 burst", 9, d);
        rd(0, ad(2, 'hC), d); chk("R2", "ch2 control low bits only", 6, d);
        rd(0, ad(1, 'h0), d); chk("R2", "ch1 period untouched", 0, d);
        rd(0, ad(2, 'h10), d); chk("R2", "unmapped offset", 0, d);
        wr(0, ad(2, 'hC), 32'h0);

        // R5 idle level
        wr(0, ad(2, 'hC), 32'h2);
        idle(3);
        measure(0, 2, 20, hi, ed); chk("R5", "inverted disabled high cycles", 20, hi);
        wr(0, ad(2, 'hC), 32'h0);
        idle(3);
        measure(0, 2, 20, hi, ed); chk("R5", "disabled high cycles", 0, hi);

        // R3 continuous waveform
        wr(0, ad(0, 'h0), 32'd10);
        wr(0, ad(0, 'h4), 32'd3);
        wr(0, ad(0, 'hC), 32'h5);
        wr(0, ad(1, 'h0), 32'd7);
        wr(0, ad(1, 'h4), 32'd5);
        wr(0, ad(1, 'hC), 32'h5);
        idle(5);
        measure(0, 0, 100, hi, ed);
        chk("R3", "ch0 high cycles P10 D3", 30, hi);
        chk("R3", "ch0 edges P10", 10, ed);
        measure(0, 1, 70, hi, ed);
        chk("R3", "ch1 high cycles P7 D5", 50, hi);
        chk("R3", "ch0 busy while running", 1, a_busy[0]);

        // R4 inversion
        wr(0, ad(0, 'hC), 32'h7);
        idle(3);
        measure(0, 0, 100, hi, ed); chk("R4", "inverted high cycles", 70, hi);
        wr(0, ad(0, 'hC), 32'h5);
        idle(3);

        // R10 boundary update
        wr(0, ad(0, 'h4), 32'd6);
        measure(0, 0, 100, hi, ed); chk("R10", "edges across update", 10, ed);
        measure(0, 0, 100, hi, ed); chk("R10", "high cycles after update", 60, hi);

        // R6 extremes
        wr(0, ad(0, 'h4), 32'd0);
        idle(25);
        measure(0, 0, 50, hi, ed); chk("R6", "high time 0", 0, hi);
        wr(0, ad(0, 'h4), 32'd15);
        idle(25);
        measure(0, 0, 50, hi, ed); chk("R6", "high time above period", 50, hi);
        wr(0, ad(0, 'h4), 32'd10);
        idle(25);
        measure(0, 0, 50, hi, ed); chk("R6", "high time equal period", 50, hi);
        wr(0, ad(0, 'h0), 32'd0);
        idle(25);
        measure(0, 0, 50, hi, ed); chk("R6", "period 0", 0, hi);
        wr(0, ad(0, 'h0), 32'd10);
        wr(0, ad(0, 'h4), 32'd3);
        idle(25);
        measure(0, 0, 100, hi, ed); chk("R6", "recovered after period 0", 30, hi);

        // R7 counted burst
        wr(0, ad(3, 'h0), 32'd8);
        wr(0, ad(3, 'h4), 32'd3);
        wr(0, ad(3, 'h8), 32'd4);
        wr(0, ad(3, 'hC), 32'h1);
        chk("R7", "busy during burst", 1, a_busy[3]);
        measure(0, 3, 60, hi, ed);
        chk("R7", "burst edges", 4, ed);
        chk("R7", "burst high cycles", 12, hi);
        chk("R7", "busy after burst", 0, a_busy[3]);
        chk("R7", "pin idle after burst", 0, a_out[3]);

        // R9 re-arm after finish
        wr(0, ad(3, 'hC), 32'h1);
        measure(0, 3, 60, hi, ed);
        chk("R9", "second burst edges", 4, ed);
        chk("R9", "second burst high cycles", 12, hi);

        // R8 zero-length burst
        wr(0, ad(3, 'h8), 32'd0);
        wr(0, ad(3, 'hC), 32'h1);
        chk("R8", "busy with zero count", 0, a_busy[3]);
        measure(0, 3, 40, hi, ed); chk("R8", "zero count high cycles", 0, hi);

        // R2 other channel still unaffected
        measure(0, 1, 70, hi, ed); chk("R2", "ch1 unchanged by others", 50, hi);

        // R11 hold until re-arm
        wr(1, ad(1, 'h0), 32'd10);
        wr(1, ad(1, 'h4), 32'd2);
        wr(1, ad(1, 'hC), 32'h5);
        idle(5);
        measure(1, 1, 100, hi, ed); chk("R11", "initial timing", 20, hi);
        wr(1, ad(1, 'h4), 32'd8);
        idle(30);
        measure(1, 1, 100, hi, ed); chk("R11", "new high held back", 20, hi);
        wr(1, ad(1, 'hC), 32'h5);
        idle(30);
        measure(1, 1, 100, hi, ed); chk("R11", "new high after re-arm", 80, hi);
        wr(1, ad(1, 'h0), 32'd20);
        idle(30);
        measure(1, 1, 100, hi, ed); chk("R11", "new period held back", 80, hi);
        wr(1, ad(1, 'hC), 32'h5);
        idle(40);
        measure(1, 1, 100, hi, ed);
        chk("R11", "period 20 high cycles", 40, hi);
        chk("R11", "period 20 edges", 5, ed);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule